// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor and a word-wide main memory as a direct-mapped data cache. Each line holds a multi-word block, one tag, a valid flag and a dirty flag. A processor access is looked up in the cycle it is presented. A hit is answered in that same cycle. A miss holds the processor stalled while the controller moves whole blocks to and from memory, one 32-bit word per handshake beat.

Writes follow a write-back, write-allocate policy. A write hit changes only the cached copy and marks the line dirty. A write miss first brings the whole block in from memory and then merges the new word into it. A line that is about to be replaced is copied back to memory only when its dirty flag is set.

The processor must hold `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_stall` low. Addresses are byte addresses and must be word aligned. The number of lines and the block length are parameters. By default there are 64 lines of 4 words each.

Top module: `dmc_cache`

## Requirements
- R1: The address is divided from the least significant end upward: 2 byte bits, which are not used, then OFF_W word-select bits [3:2], then INDEX_W line-select bits, then the tag in the remaining upper bits. A lookup hits only when the selected line is valid and its stored tag equals the address tag.
- R2: On a read hit, `cpu_stall` is low and `cpu_hit` is high in the cycle the request is presented. `cpu_rdata` is then the word chosen by the word-select field. No memory transfer takes place.
- R3: A write hit updates only the cached word and sets the line's dirty flag. No memory write occurs, and the memory copy of that word keeps its old value.
- R4: A miss keeps `cpu_stall` high from the first cycle of the request until a completion cycle, in which `cpu_stall` is low and `cpu_hit` is low. That completion cycle comes one cycle after the last fetch beat.
- R5: When the victim line is valid and dirty, its block is first written to memory in exactly 2^OFF_W write beats. The beat addresses are {victim tag, index, word 0,1,2,..., 2'b00} in ascending order, and the data is the latest cached data. All of these beats come before the first fetch beat.
- R6: When the victim line is invalid or clean, no memory write beat occurs.
- R7: Every miss fetches the block in exactly 2^OFF_W read beats, at addresses {request tag, index, word 0,1,2,..., 2'b00} in ascending order. The line then becomes valid with the new tag and is clean, so a read miss returns the fetched word.
- R8: On a write miss, the new word is merged into the fetched block and the line is marked dirty. The other words of the block hold the values from memory.
- R9: Reset clears every valid and dirty flag, leaves `cpu_stall` and `mem_req` low, and makes the first access to each index a miss.
- R10: A memory beat completes only when `mem_req` and `mem_ack` are both high. While `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and the write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_stall` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when the request completes |
| cpu_hit | output | 1 | Request completed on its first lookup |
| cpu_stall | output | 1 | Request pending; processor must wait |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = writeback beat, 0 = fetch beat |
| mem_addr | output | 32 | Byte address of the word in the current beat |
| mem_wdata | output | 32 | Word sent on a writeback beat |
| mem_rdata | input | 32 | Word returned on a fetch beat |
| mem_ack | input | 1 | Memory accepts the current beat |

## Verification
The bound checker watches the memory handshake and the processor stall on every cycle. It checks that a beat is held steady until it is acknowledged, and that addresses step upward by one word within a writeback and within a fetch. It also checks that a writeback is always followed by a fetch, that the stall falls right after the last fetch beat, and that a hit never stalls and never touches memory. Three things need the bench's scenarios and its shadow model of tags, dirty flags and memory contents: whether a given access should hit, whether a victim is dirty enough to be written back, and whether the data returned or written is the correct value. Those scenarios cover cold misses, write hits followed by dirty eviction, clean eviction, write-miss merging and a long random mix with stalling memory.

// File: rtl/dmc_pkg.sv
// Package dmc_pkg
// Shared types for the direct-mapped cache: the controller state encoding.
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FETCH = 2'd2,
        ST_DONE  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_tags.sv
// Module dmc_tags
// Holds the tag, valid flag and dirty flag of every cache line in registers.
// Assumes one index is in use per cycle. A fill makes that line valid and
// clean with a new tag, and a dirty mark sets the dirty flag. Reads are
// combinational.
module dmc_tags #(
    parameter int INDEX_W = 6,
    parameter int TAG_W   = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic               fill_en,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               dirty_en,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Flag update: reset clears, fill validates and cleans, write dirties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_en) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag storage: loaded with the new tag on every fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];
endmodule

// File: rtl/dmc_data.sv
// Module dmc_data
// Block data storage built as one register lane per word position.
// Assumes a single word is written per cycle. The whole block at the
// selected index is read combinationally as an array of words.
module dmc_data #(
    parameter int INDEX_W = 6,
    parameter int OFF_W   = 2,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] idx,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_word,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  rd_words [1 << OFF_W]
);
    localparam int LINES = 1 << INDEX_W;
    localparam int WORDS = 1 << OFF_W;

    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        logic [WORD_W-1:0] lane_q [LINES];

        // Lane write: accepts the word only when this lane is selected.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_word == OFF_W'(w))) begin
                lane_q[idx] <= wr_data;
            end
        end

        assign rd_words[w] = lane_q[idx];
    end
endmodule

// File: rtl/dmc_ctrl.sv
// Module dmc_ctrl
// Miss sequencer. From idle it goes to writeback when the victim is dirty,
// and otherwise straight to fetch. Each of those phases moves 2^OFF_W beats.
// A one-cycle completion state then releases the processor. Assumes the
// processor holds its request stable while stalled.
module dmc_ctrl #(
    parameter int OFF_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 lookup_hit,
    input  logic                 victim_dirty,
    input  logic                 mem_ack,
    output dmc_pkg::dmc_state_e  state_o,
    output logic [OFF_W-1:0]     beat_o,
    output logic                 mem_busy,
    output logic                 beat_go,
    output logic                 last_beat,
    output logic                 first_hit,
    output logic                 req_done
);
    import dmc_pkg::*;

    dmc_state_e       state_q;
    logic [OFF_W-1:0] beat_q;

    assign mem_busy  = (state_q == ST_WBACK) || (state_q == ST_FETCH);
    assign beat_go   = mem_busy && mem_ack;
    assign last_beat = beat_go && (&beat_q);
    assign first_hit = (state_q == ST_IDLE) && cpu_req && lookup_hit;
    assign req_done  = first_hit || (state_q == ST_DONE);

    // State and beat counter: steps through the miss phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    beat_q <= '0;
                    if (cpu_req && !lookup_hit) begin
                        state_q <= victim_dirty ? ST_WBACK : ST_FETCH;
                    end
                end
                ST_WBACK: begin
                    if (beat_go) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (beat_go) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign beat_o  = beat_q;
endmodule

// File: rtl/dmc_cache.sv
// Module dmc_cache
// Top level of the direct-mapped write-back, write-allocate data cache.
// Splits the processor address into its fields, looks up the tag store and
// drives the memory beat interface from the controller state. Assumes word-
// aligned addresses and a processor that holds its request while stalled.
module dmc_cache #(
    parameter int INDEX_W = 6,
    parameter int OFF_W   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_hit,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack
);
    import dmc_pkg::*;

    localparam int BYTE_W = 2;
    localparam int WORDS  = 1 << OFF_W;
    localparam int TAG_W  = 32 - INDEX_W - OFF_W - BYTE_W;

    logic [OFF_W-1:0]   req_off;
    logic [INDEX_W-1:0] req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic               byte_unused;

    logic               rd_valid, rd_dirty;
    logic [TAG_W-1:0]   rd_tag;
    logic [31:0]        rd_words [WORDS];

    dmc_state_e         state;
    logic [OFF_W-1:0]   beat;
    logic               busy, beat_go, last_beat, first_hit, req_done;
    logic               lookup_hit, victim_dirty;
    logic               wr_fill, cpu_wr;

    assign req_off     = cpu_addr[BYTE_W +: OFF_W];
    assign req_idx     = cpu_addr[BYTE_W + OFF_W +: INDEX_W];
    assign req_tag     = cpu_addr[31 -: TAG_W];
    assign byte_unused = ^cpu_addr[BYTE_W-1:0];

    assign lookup_hit   = rd_valid && (rd_tag == req_tag);
    assign victim_dirty = rd_valid && rd_dirty;

    dmc_ctrl #(.OFF_W(OFF_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .lookup_hit   (lookup_hit),
        .victim_dirty (victim_dirty),
        .mem_ack      (mem_ack),
        .state_o      (state),
        .beat_o       (beat),
        .mem_busy     (busy),
        .beat_go      (beat_go),
        .last_beat    (last_beat),
        .first_hit    (first_hit),
        .req_done     (req_done)
    );

    assign wr_fill = (state == ST_FETCH) && beat_go;
    assign cpu_wr  = req_done && cpu_we;

    dmc_tags #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .fill_en  ((state == ST_FETCH) && last_beat),
        .fill_tag (req_tag),
        .dirty_en (cpu_wr),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag)
    );

    dmc_data #(.INDEX_W(INDEX_W), .OFF_W(OFF_W), .WORD_W(32)) u_data (
        .clk      (clk),
        .idx      (req_idx),
        .wr_en    (wr_fill || cpu_wr),
        .wr_word  (wr_fill ? beat : req_off),
        .wr_data  (wr_fill ? mem_rdata : cpu_wdata),
        .rd_words (rd_words)
    );

    assign cpu_rdata = rd_words[req_off];
    assign cpu_hit   = first_hit;
    assign cpu_stall = cpu_req && !req_done;

    assign mem_req   = busy;
    assign mem_we    = (state == ST_WBACK);
    assign mem_addr  = {(state == ST_WBACK) ? rd_tag : req_tag, req_idx, beat,
                        {BYTE_W{1'b0}}};
    assign mem_wdata = rd_words[beat];
endmodule

// File: rtl/dmc_cache_chk.sv
// Module dmc_cache_chk
// Cycle-level protocol checks on the ports of dmc_cache, attached by bind.
module dmc_cache_chk #(
    parameter int OFF_W = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_hit,
    input logic        cpu_stall,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    logic beat_acc, beat_end;
    assign beat_acc = mem_req && mem_ack;
    assign beat_end = &mem_addr[2 +: OFF_W];

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata)));

    // R4
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> cpu_req);

    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (!cpu_stall && !mem_req));

    // R5
    wb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && mem_we && !beat_end) |=>
            (mem_req && mem_we && (mem_addr == $past(mem_addr) + 32'd4)));

    // R5
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && mem_we && beat_end) |=> (mem_req && !mem_we));

    // R7
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && !mem_we && !beat_end) |=>
            (mem_req && !mem_we && (mem_addr == $past(mem_addr) + 32'd4)));

    // R4
    fill_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && !mem_we && beat_end) |=> (!mem_req && !cpu_stall && !cpu_hit));
endmodule

bind dmc_cache dmc_cache_chk #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_hit   (cpu_hit),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/dmc_cache_bench.sv
`timescale 1ns/1ps
// Bench for dmc_cache with 4 lines of 4 words. A shadow model of the tags,
// dirty flags and memory contents predicts every outcome.
module dmc_cache_bench;
    localparam int IW = 2;
    localparam int OW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_hit, cpu_stall;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem  [256];
    logic [31:0] refm [256];
    bit          mval [4];
    bit          mdirty [4];
    int          mtag [4];

    int          n_checks = 0, n_err = 0;
    int          wb_cnt = 0, fe_cnt = 0;
    int          wb_base = 0, fe_base = 0;
    string       phase_tag = "";
    bit          ack_all = 1'b1;
    logic [7:0]  ack_sh = 8'h5B;

    always #10 clk = ~clk;

    dmc_cache #(.INDEX_W(IW), .OFF_W(OW)) u_dmc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign mem_ack   = mem_req && (ack_all || ack_sh[0]);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) ack_sh <= {ack_sh[6:0], ack_sh[7] ^ ack_sh[5] ^ ack_sh[4] ^ ack_sh[3]};

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Memory model and beat monitor, sampled between clock edges.
    always @(negedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                check(mem_addr == 32'(wb_base + wb_cnt * 4), "R5 wb addr", mem_addr,
                      32'(wb_base + wb_cnt * 4));
                check(mem_wdata == refm[mem_addr[9:2]], "R5 wb data", mem_wdata,
                      refm[mem_addr[9:2]]);
                check(fe_cnt == 0, "R5 wb before fetch", 32'(fe_cnt), 32'd0);
                mem[mem_addr[9:2]] = mem_wdata;
                wb_cnt++;
            end else begin
                check(mem_addr == 32'(fe_base + fe_cnt * 4), "R7 fetch addr", mem_addr,
                      32'(fe_base + fe_cnt * 4));
                fe_cnt++;
            end
        end
    end

    task automatic access(input bit we, input int w, input logic [31:0] d);
        int          idx = (w >> 2) & 3;
        int          tg = w >> 4;
        bit          exp_hit;
        int          exp_wb;
        int          to = 0;
        string       ht;
        logic [31:0] old_mem;
        old_mem = mem[w];
        exp_hit = mval[idx] && (mtag[idx] == tg);
        exp_wb  = (!exp_hit && mval[idx] && mdirty[idx]) ? 4 : 0;
        ht      = mval[idx] ? "R1 hit" : "R9 cold miss";
        @(negedge clk);
        wb_cnt = 0; fe_cnt = 0;
        wb_base = (mtag[idx] << 6) | (idx << 4);
        fe_base = (tg << 6) | (idx << 4);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 32'(w) << 2; cpu_wdata = d;
        #1;
        check(cpu_hit == exp_hit, ht, {31'b0, cpu_hit}, {31'b0, exp_hit});
        if (exp_hit) check(!cpu_stall, "R2 no stall", {31'b0, cpu_stall}, 32'd0);
        else check(cpu_stall, "R4 stall", {31'b0, cpu_stall}, 32'd1);
        while (cpu_stall && to < 300) begin
            @(negedge clk); #1; to++;
        end
        check(!cpu_stall, "R4 release", {31'b0, cpu_stall}, 32'd0);
        if (!exp_hit) check(!cpu_hit, "R4 done hit low", {31'b0, cpu_hit}, 32'd0);
        if (!we) check(cpu_rdata == refm[w], (phase_tag != "") ? phase_tag :
                       (exp_hit ? "R2 read" : "R7 read"), cpu_rdata, refm[w]);
        @(posedge clk); #1;
        check(wb_cnt == exp_wb, exp_wb != 0 ? "R5 wb beats" : "R6 no wb",
              32'(wb_cnt), 32'(exp_wb));
        check(fe_cnt == (exp_hit ? 0 : 4), "R7 fetch beats", 32'(fe_cnt),
              exp_hit ? 32'd0 : 32'd4);
        if (we && exp_hit) check(mem[w] == old_mem, "R3 mem untouched", mem[w], old_mem);
        if (!exp_hit) begin mval[idx] = 1'b1; mtag[idx] = tg; mdirty[idx] = 1'b0; end
        if (we) begin mdirty[idx] = 1'b1; refm[w] = d; end
        cpu_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL R4 watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] r = 32'h1234_ABCD;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A, 8'hC3};
            refm[i] = mem[i];
        end
        for (int i = 0; i < 4; i++) begin mval[i] = 0; mdirty[i] = 0; mtag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!cpu_stall, "R9 reset stall", {31'b0, cpu_stall}, 32'd0);
        check(!mem_req, "R9 reset mem_req", {31'b0, mem_req}, 32'd0);
        // Cold fills, then hits on the remaining words (R9, R2).
        for (int i = 0; i < 4; i++) begin
            access(0, i * 4, '0);
            for (int k = 1; k < 4; k++) access(0, i * 4 + k, '0);
        end
        // Write hits (R3), then dirty eviction (R5).
        for (int i = 0; i < 4; i++) access(1, i * 4 + 1, 32'hD000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) access(0, 16 + i * 4 + 2, '0);
        // Clean eviction (R6).
        for (int i = 0; i < 4; i++) access(0, 32 + i * 4, '0);
        // Write miss merge (R8), then eviction of the merged line.
        for (int i = 0; i < 4; i++) begin
            access(1, 48 + i * 4 + 3, 32'hE000_0000 + 32'(i));
            phase_tag = "R8 merge";
            for (int k = 0; k < 4; k++) access(0, 48 + i * 4 + k, '0);
            phase_tag = "";
            access(0, i * 4 + 1, '0);
        end
        // Random mix with a stalling memory (R10).
        ack_all = 1'b0;
        for (int n = 0; n < 1500; n++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            access(r[31], int'(r[7:0]), r ^ 32'h0F0F_0F0F);
        end
        finish_run();
    end
endmodule